// File: doc/BRIEF.md
# Process-Sensor Voltage Code Generator

This block picks a supply voltage level for the die it sits on. Two free-running ring oscillators are sampled. One is built from low-threshold cells and one from medium-threshold cells. The block counts the rising edges of each oscillator during a measurement window of a programmable number of reference-clock cycles. Each count is compared against its own set of six ascending thresholds, which turns it into a process code from 0 (slowest corner) to 6 (fastest corner). The two process codes, together with a temperature mode and a clock mode, select one entry of a loadable process-to-voltage table. The entry is a voltage code from 0 to 4, meaning 1.10 V to 1.30 V in 50 mV steps.

The selected code is passed to the external DC-DC converter only after two consecutive measurements agree on it. This keeps a noisy sensor reading from dithering the supply. The tables are filled through a single-cycle write port. The sensor path has no connection to the user logic, so only the process-to-voltage table has to be re-derived for a new design.

Top module: `asv_code_gen`

## Requirements
- R1: After reset, `vcode` is 4 and `vcode_load` is 0. All thresholds reset to 0 and every voltage entry resets to 4, so a block that was never loaded keeps driving 4.
- R2: A measurement window lasts `win_len` reference cycles, with 0 treated as 1. The count for each sensor is the number of its rising edges within one window, accurate to one edge.
- R3: A process code is the number of that sensor's six thresholds that are less than or equal to its count. This saturates at 0 for very slow counts and at 6 for very fast counts. Thresholds are written with `cfg_tbl`=0, where `cfg_addr[3]` selects the sensor (0 low-threshold, 1 medium-threshold) and `cfg_addr[2:0]` is the index 0..5.
- R4: The looked-up entry is at index set*49 + pl*7 + pm, where set = {`temp_mode`,`clk_mode`}, pl is the low-threshold process code and pm is the medium-threshold process code. Entries are written with `cfg_tbl`=1, `cfg_addr` = index and `cfg_data[2:0]`, and a write takes effect in later lookups.
- R5: `vcode` changes only when two consecutive lookups return the same value and that value differs from the current `vcode`. `vcode_load` pulses high for exactly the cycle in which the new `vcode` first appears.
- R6: A lookup result that differs for one window only leaves `vcode` unchanged and raises no `vcode_load`. `vcode_load` is never high in two consecutive cycles.
- R7: The following writes are ignored: voltage-table writes with an index of 196 or more, and threshold writes with an index of 6 or 7 or with any address bit above bit 3 set.
- R8: A voltage-table write whose data exceeds 4 stores 4.
- R9: `vcode` never exceeds 4, and code k stands for 1.10 V + k * 50 mV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_lo | input | 1 | Low-threshold ring oscillator output |
| osc_md | input | 1 | Medium-threshold ring oscillator output |
| win_len | input | 10 | Measurement window length in reference cycles |
| temp_mode | input | 1 | Temperature mode, upper bit of the table set |
| clk_mode | input | 1 | Clock mode, lower bit of the table set |
| cfg_we | input | 1 | Table write strobe |
| cfg_tbl | input | 1 | 0 selects the thresholds, 1 selects the voltage table |
| cfg_addr | input | 8 | Table write address |
| cfg_data | input | 12 | Table write data |
| vcode | output | 3 | Voltage code to the converter |
| vcode_load | output | 1 | One-cycle pulse when `vcode` changes |

## Verification
The table of vectors drives combinations of oscillator periods and mode settings. In each vector the two sensors land on different process codes, so swapped sensors or transposed table axes give a wrong voltage. Very slow and very fast periods exercise the clamped codes at both ends. Holding a different mode for exactly one window, and then for exactly two windows, separates the agreement filter from a plain register. Doubling the window length shifts the codes, and writes to aliasing-prone addresses and with oversized data check the limits of the write port.

// File: rtl/asv_pkg.sv
package asv_pkg;
    localparam int NUM_SENS = 2;                       // low-threshold, medium-threshold
    localparam int NUM_PC   = 7;                       // process codes per sensor
    localparam int NUM_THR  = NUM_PC - 1;              // thresholds per sensor
    localparam int NUM_SET  = 4;                       // temperature x clock mode sets
    localparam int NUM_VLV  = 5;                       // voltage levels
    localparam int PC_W     = $clog2(NUM_PC);
    localparam int V_W      = $clog2(NUM_VLV);
    localparam int SET_W    = $clog2(NUM_SET);
    localparam int THR_IDX_W = $clog2(NUM_THR);
    localparam int PV_DEPTH = NUM_SET * NUM_PC * NUM_PC;
endpackage

// File: rtl/asv_osc_counter.sv
// Counts oscillator edges in the oscillator domain and hands a Gray-coded
// value to the reference domain; output is the binary count seen there.
module asv_osc_counter #(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             osc,
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] bin_q, bin_d, gray_q;
    logic [SYNC_STAGES-1:0][CNT_W-1:0] sync_q;

    function automatic logic [CNT_W-1:0] gray2bin(input logic [CNT_W-1:0] g);
        logic [CNT_W-1:0] b;
        b[CNT_W-1] = g[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    assign bin_d = bin_q + CNT_W'(1);

    always_ff @(posedge osc or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_d;
            gray_q <= bin_d ^ (bin_d >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], gray_q};
    end

    assign count = gray2bin(sync_q[SYNC_STAGES-1]);
endmodule

// File: rtl/asv_f2p.sv
// Frequency-to-process conversion: code = number of thresholds at or below the count.
module asv_f2p #(
    parameter int CNT_W   = 12,
    parameter int NUM_THR = 6,
    parameter int PC_W    = 3
) (
    input  logic [CNT_W-1:0]              count,
    input  logic [NUM_THR-1:0][CNT_W-1:0] thr,
    output logic [PC_W-1:0]               pcode
);
    always_comb begin
        pcode = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            if (count >= thr[i]) pcode = pcode + PC_W'(1);
        end
    end
endmodule

// File: rtl/asv_code_gen.sv
module asv_code_gen
    import asv_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int WIN_W       = 10,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_lo,
    input  logic              osc_md,
    input  logic [WIN_W-1:0]  win_len,
    input  logic              temp_mode,
    input  logic              clk_mode,
    input  logic              cfg_we,
    input  logic              cfg_tbl,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_data,
    output logic [V_W-1:0]    vcode,
    output logic              vcode_load
);
    localparam logic [V_W-1:0] V_MAX = V_W'(NUM_VLV - 1);

    typedef struct packed {
        logic [WIN_W-1:0]                 wcnt;
        logic [NUM_SENS-1:0][CNT_W-1:0]   snap;
        logic [NUM_SENS-1:0][CNT_W-1:0]   diff;
        logic                             meas;
        logic [V_W-1:0]                   prev;
        logic                             prev_vld;
        logic [V_W-1:0]                   vcode;
        logic                             load;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_SENS-1:0]                          osc_in;
    logic [NUM_SENS-1:0][CNT_W-1:0]               cnt;
    logic [NUM_SENS-1:0][PC_W-1:0]                pcode;
    logic [NUM_SENS-1:0][NUM_THR-1:0][CNT_W-1:0]  thr_q;
    logic [V_W-1:0]                               pv_q [PV_DEPTH];
    logic [SET_W-1:0]                             set_sel;
    logic [ADDR_W-1:0]                            pv_idx;
    logic [V_W-1:0]                               lookup;
    logic                                         win_end;
    logic                                         thr_we, pv_we;
    logic [V_W-1:0]                               pv_wdata;

    assign osc_in = {osc_md, osc_lo};

    for (genvar s = 0; s < NUM_SENS; s++) begin : g_sens
        asv_osc_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
            .osc(osc_in[s]), .clk(clk), .rst_n(rst_n), .count(cnt[s])
        );
        asv_f2p #(.CNT_W(CNT_W), .NUM_THR(NUM_THR), .PC_W(PC_W)) u_f2p (
            .count(st_q.diff[s]), .thr(thr_q[s]), .pcode(pcode[s])
        );
    end

    // Table write port
    assign thr_we = cfg_we && !cfg_tbl
                 && (cfg_addr[ADDR_W-1:THR_IDX_W+1] == '0)
                 && (cfg_addr[THR_IDX_W-1:0] < THR_IDX_W'(NUM_THR));
    assign pv_we    = cfg_we && cfg_tbl && (cfg_addr < ADDR_W'(PV_DEPTH));
    assign pv_wdata = (cfg_data > CNT_W'(NUM_VLV - 1)) ? V_MAX : cfg_data[V_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      thr_q <= '0;
        else if (thr_we) thr_q[cfg_addr[THR_IDX_W]][cfg_addr[THR_IDX_W-1:0]] <= cfg_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PV_DEPTH; i++) pv_q[i] <= V_MAX;
        end else if (pv_we) begin
            pv_q[cfg_addr] <= pv_wdata;
        end
    end

    // Two-dimensional lookup
    assign set_sel = {temp_mode, clk_mode};
    assign pv_idx  = ADDR_W'(int'(set_sel) * NUM_PC * NUM_PC
                           + int'(pcode[0]) * NUM_PC + int'(pcode[1]));
    assign lookup  = pv_q[pv_idx];

    always_comb begin
        st_d      = st_q;
        st_d.meas = 1'b0;
        st_d.load = 1'b0;
        win_end   = ({1'b0, st_q.wcnt} + (WIN_W+1)'(1)) >= {1'b0, win_len};
        if (win_end) begin
            st_d.wcnt = '0;
            st_d.meas = 1'b1;
            for (int s = 0; s < NUM_SENS; s++) begin
                st_d.snap[s] = cnt[s];
                st_d.diff[s] = cnt[s] - st_q.snap[s];
            end
        end else begin
            st_d.wcnt = st_q.wcnt + WIN_W'(1);
        end
        if (st_q.meas) begin
            st_d.prev     = lookup;
            st_d.prev_vld = 1'b1;
            if (st_q.prev_vld && (lookup == st_q.prev) && (lookup != st_q.vcode)) begin
                st_d.vcode = lookup;
                st_d.load  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.vcode <= V_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign vcode      = st_q.vcode;
    assign vcode_load = st_q.load;
endmodule

// File: rtl/asv_code_gen_chk.sv
module asv_code_gen_chk
    import asv_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [V_W-1:0]  vcode,
    input logic            vcode_load,
    input logic [PC_W-1:0] pcode_lo,
    input logic [PC_W-1:0] pcode_md
);
    assert_vcode_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vcode <= V_W'(NUM_VLV - 1));

    assert_pcode_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pcode_lo <= PC_W'(NUM_PC - 1)) && (pcode_md <= PC_W'(NUM_PC - 1)));

    assert_load_marks_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vcode_load |-> (vcode != $past(vcode)));

    assert_hold_without_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !vcode_load |-> $stable(vcode));

    assert_no_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vcode_load |=> !vcode_load);
endmodule

bind asv_code_gen asv_code_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .vcode(vcode), .vcode_load(vcode_load),
    .pcode_lo(pcode[0]), .pcode_md(pcode[1])
);

// File: tb/asv_code_gen_bench.sv
module asv_code_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 7;
    // lo half-period, md half-period, temp_mode, clk_mode, expected pl, expected pm
    localparam int VEC [NV][6] = '{
        '{15, 10, 0, 0, 1, 2},
        '{ 7, 25, 0, 1, 3, 0},
        '{ 6, 15, 1, 0, 4, 1},
        '{25,  2, 1, 0, 0, 6},   // both saturating ends (R3)
        '{ 2, 25, 1, 1, 6, 0},
        '{ 5,  3, 0, 0, 5, 6},
        '{ 3,  7, 0, 1, 6, 3}
    };
    localparam int THR [6] = '{25, 40, 60, 77, 90, 140};

    logic        clk = 0, rst_n = 0, osc_lo = 0, osc_md = 0;
    logic [9:0]  win_len = 10'd100;
    logic        temp_mode = 0, clk_mode = 0, cfg_we = 0, cfg_tbl = 0;
    logic [7:0]  cfg_addr = '0;
    logic [11:0] cfg_data = '0;
    logic [2:0]  vcode;
    logic        vcode_load;

    int lo_half = 15, md_half = 10;
    int checks = 0, errors = 0, loads = 0;
    bit done = 0;

    asv_code_gen u_asv_code_gen (.*);

    always #(CLK_PERIOD/2) clk = ~clk;
    initial forever #(lo_half) osc_lo = ~osc_lo;
    initial forever #(md_half) osc_md = ~osc_md;
    always @(posedge clk) begin #1; if (vcode_load) loads++; end

    function automatic int vfun(int set, int pl, int pm);
        return (pl * 3 + pm + set * 2) % 5;
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(bit tbl, int addr, int data);
        @(negedge clk);
        cfg_we = 1; cfg_tbl = tbl; cfg_addr = 8'(addr); cfg_data = 12'(data);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic wait_win(int n);
        repeat (n * int'(win_len)) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset vcode", int'(vcode), 4);
        check("R1 reset vcode_load", int'(vcode_load), 0);
        rst_n = 1;
        wait_win(4);
        check("R1 unloaded tables keep 4", int'(vcode), 4);

        for (int i = 0; i < 6; i++) begin
            wr(0, i, THR[i]);
            wr(0, 8 + i, THR[i]);
        end
        for (int s = 0; s < 4; s++)
            for (int pl = 0; pl < 7; pl++)
                for (int pm = 0; pm < 7; pm++)
                    wr(1, s * 49 + pl * 7 + pm, vfun(s, pl, pm));

        // Vector walk (R3, R4, R5)
        for (int i = 0; i < NV; i++) begin
            lo_half = VEC[i][0]; md_half = VEC[i][1];
            temp_mode = VEC[i][2][0]; clk_mode = VEC[i][3][0];
            wait_win(5);
            check($sformatf("R4 vector %0d (R3 codes %0d,%0d)", i, VEC[i][4], VEC[i][5]),
                  int'(vcode), vfun(VEC[i][2] * 2 + VEC[i][3], VEC[i][4], VEC[i][5]));
        end

        // One-window mode deviation: exactly one lookup sees it (R6)
        @(negedge clk); loads = 0; temp_mode = 1;
        repeat (int'(win_len)) @(negedge clk);
        temp_mode = 0;
        wait_win(3);
        check("R6 single-window deviation vcode", int'(vcode), 3);
        check("R6 single-window deviation loads", loads, 0);

        // Two-window mode change: exactly two lookups, second updates (R5)
        @(negedge clk); loads = 0; temp_mode = 1;
        repeat (2 * int'(win_len)) @(negedge clk);
        check("R5 two agreeing lookups vcode", int'(vcode), 2);
        check("R5 two agreeing lookups loads", loads, 1);

        // Table port corner cases, set 0, pl 1, pm 2 -> index 9
        temp_mode = 0; clk_mode = 0; lo_half = 15; md_half = 10;
        wait_win(5);
        check("R4 index 9 value", int'(vcode), 0);
        wr(0, 8'h10, 4095);   // address bit 4 set: ignored
        wr(1, 205, 3);        // index beyond 195: ignored
        wait_win(4);
        check("R7 ignored writes", int'(vcode), 0);
        wr(1, 9, 6);
        wait_win(4);
        check("R8 oversized data saturates", int'(vcode), 4);
        wr(1, 9, 1);
        wait_win(4);
        check("R4 live table write", int'(vcode), 1);
        wr(0, 1, 30);         // lo count 33 now reaches code 2 -> index 16
        wait_win(4);
        check("R3 reloaded threshold", int'(vcode), 3);

        // Longer window doubles the counts (R2): pl 3, pm 5 -> 4
        win_len = 10'd200;
        wait_win(5);
        check("R2 window length 200", int'(vcode), 4);
        check("R9 vcode in range", int'(vcode <= 3'd4), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule